// File: doc/BRIEF.md
# Integer Execute Unit with HI/LO Move Registers

This block is the execute stage of a 32-bit load/store integer core whose instructions use the classic three-field layout. The decoder ahead of it supplies the primary opcode, the function code, the shift amount field, the two destination register indices and the 16-bit immediate, along with the two source operand values read from the register file. In the same cycle the unit returns the value to write back, the index of the register to write, and a write enable.

Every general-register result is combinational. A pair of special registers, HI and LO, lives inside the unit. It is loaded on a rising clock edge by the two move-to instructions and read back by the two move-from instructions. The conditional moves can hold back the write-back depending on the second operand. A write aimed at register 0 is always dropped. An encoding the unit does not recognise writes nothing. Overflow raises no trap, and the add forms wrap modulo 2^32.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0, funct 32 (ADD) and 33 (ADDU) return rs+rt, and funct 34 (SUB) and 35 (SUBU) return rs-rt. All four wrap modulo 2^32 with no trap and write register rd.
- R2: Opcodes 8 (ADDI) and 9 (ADDIU) return rs plus the sign-extended 16-bit immediate, and the write index is the rt field.
- R3: Funct 42 (SLT) compares rs<rt signed and funct 43 (SLTU) compares unsigned, returning 1 or 0. Opcode 10 (SLTI) compares rs with the sign-extended immediate as signed values. Opcode 11 (SLTIU) compares rs with the same sign-extended immediate as unsigned values.
- R4: Funct 36/37/38/39 return rs AND/OR/XOR/NOR rt. Opcodes 12/13/14 return rs AND/OR/XOR the zero-extended immediate.
- R5: Funct 0 (SLL), 2 (SRL) and 3 (SRA) shift rt by the shamt field. SRA copies the sign bit into the vacated positions, and SRL fills them with zeros.
- R6: Funct 4 (SLLV), 6 (SRLV) and 7 (SRAV) shift rt by the low 5 bits of rs, and the upper bits of rs are ignored.
- R7: When issue is high, funct 17 (MTHI) and 19 (MTLO) load rs into HI or LO on the next rising clock edge and assert no write enable. Funct 16 (MFHI) and 18 (MFLO) return HI or LO and write rd.
- R8: Funct 10 (MOVZ) returns rs and enables the write only when rt is zero. Funct 11 (MOVN) returns rs and enables the write only when rt is nonzero.
- R9: The write enable is never high when the write index is 0.
- R10: Encodings outside those listed leave the write enable low and do not change HI or LO. Examples are funct 1 or 5 with opcode 0, and opcode 15.
- R11: A synchronous active-low reset clears HI and LO to zero.
- R12: With issue low, the write enable is low and HI/LO keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for HI/LO |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | An instruction is present this cycle |
| op_code | input | 6 | Primary opcode field |
| fn_code | input | 6 | Function field (opcode 0) |
| sh_amt | input | 5 | Shift amount field |
| rt_sel | input | 5 | rt register index |
| rd_sel | input | 5 | rd register index |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| imm16 | input | 16 | Immediate field |
| res | output | 32 | Write-back value |
| wr_idx | output | 5 | Write-back register index |
| wr_en | output | 1 | Write-back enable |

## Verification
The bench goes after the places where each extension rule matters. XORI with an immediate whose bit 15 is set would give a different upper half under sign extension. SLTIU with immediate 0xFFFF must compare as 0xFFFFFFFF, so a unit that zero-extends would answer differently. Arithmetic right shift of a negative word must return 0xF000001E, and a unit that fills with zeros would return 0x1000001E. A variable shift of 35 must act as 3, so a unit that uses every rs bit would return 0. The bench also checks that conditional moves hold the write back in the right case, that writes to register 0 and unknown encodings are dropped, and that an MTHI with issue low leaves HI unchanged when read back through MFHI.

// File: rtl/exu_pkg.sv
// Shared encodings and control word for the integer execute unit.
// Assumes the classic 6-bit opcode / 6-bit function field layout.
package exu_pkg;

    // Primary opcodes
    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_ADDI    = 6'd8;
    localparam logic [5:0] OPC_ADDIU   = 6'd9;
    localparam logic [5:0] OPC_SLTI    = 6'd10;
    localparam logic [5:0] OPC_SLTIU   = 6'd11;
    localparam logic [5:0] OPC_ANDI    = 6'd12;
    localparam logic [5:0] OPC_ORI     = 6'd13;
    localparam logic [5:0] OPC_XORI    = 6'd14;

    // Function codes under opcode 0
    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_SRA  = 6'd3;
    localparam logic [5:0] FN_SLLV = 6'd4;
    localparam logic [5:0] FN_SRLV = 6'd6;
    localparam logic [5:0] FN_SRAV = 6'd7;
    localparam logic [5:0] FN_MOVZ = 6'd10;
    localparam logic [5:0] FN_MOVN = 6'd11;
    localparam logic [5:0] FN_MFHI = 6'd16;
    localparam logic [5:0] FN_MTHI = 6'd17;
    localparam logic [5:0] FN_MFLO = 6'd18;
    localparam logic [5:0] FN_MTLO = 6'd19;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_XOR  = 6'd38;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;
    localparam logic [5:0] FN_SLTU = 6'd43;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR
    } alu_fn_e;

    typedef enum logic [1:0] { OPB_REG, OPB_SEXT, OPB_ZEXT } opb_e;

    typedef enum logic [1:0] { SH_LL, SH_RL, SH_RA } sh_kind_e;

    typedef enum logic [2:0] { RES_ALU, RES_SHIFT, RES_HI, RES_LO, RES_PASS } res_e;

    typedef enum logic [1:0] { WR_NONE, WR_ALWAYS, WR_IF_ZERO, WR_IF_NONZERO } wr_cond_e;

    typedef struct packed {
        alu_fn_e  alu;
        opb_e     opb;
        sh_kind_e sh;
        logic     sh_var;
        logic     dst_rt;
        res_e     res;
        wr_cond_e wr;
        logic     hi_we;
        logic     lo_we;
    } ctl_t;

endpackage

// File: rtl/exu_decode.sv
// Instruction field decoder: turns opcode/function fields into a control word.
// Assumes unknown encodings should write nothing; such encodings keep the
// default control word (WR_NONE, no HI/LO load).
module exu_decode
    import exu_pkg::*;
(
    input  logic [5:0] op_code,
    input  logic [5:0] fn_code,
    output ctl_t       ctl
);

    // Maps each recognised encoding onto datapath selects and write policy.
    always_comb begin
        ctl = '{alu: ALU_ADD, opb: OPB_REG, sh: SH_LL, sh_var: 1'b0,
                dst_rt: 1'b0, res: RES_ALU, wr: WR_NONE,
                hi_we: 1'b0, lo_we: 1'b0};
        if (op_code == OPC_SPECIAL) begin
            unique case (fn_code)
                FN_ADD, FN_ADDU: begin ctl.alu = ALU_ADD;  ctl.wr = WR_ALWAYS; end
                FN_SUB, FN_SUBU: begin ctl.alu = ALU_SUB;  ctl.wr = WR_ALWAYS; end
                FN_AND:          begin ctl.alu = ALU_AND;  ctl.wr = WR_ALWAYS; end
                FN_OR:           begin ctl.alu = ALU_OR;   ctl.wr = WR_ALWAYS; end
                FN_XOR:          begin ctl.alu = ALU_XOR;  ctl.wr = WR_ALWAYS; end
                FN_NOR:          begin ctl.alu = ALU_NOR;  ctl.wr = WR_ALWAYS; end
                FN_SLT:          begin ctl.alu = ALU_SLT;  ctl.wr = WR_ALWAYS; end
                FN_SLTU:         begin ctl.alu = ALU_SLTU; ctl.wr = WR_ALWAYS; end
                FN_SLL, FN_SRL, FN_SRA, FN_SLLV, FN_SRLV, FN_SRAV: begin
                    ctl.res    = RES_SHIFT;
                    ctl.wr     = WR_ALWAYS;
                    ctl.sh_var = fn_code[2];
                    ctl.sh     = (fn_code[1:0] == 2'd0) ? SH_LL :
                                 (fn_code[1:0] == 2'd2) ? SH_RL : SH_RA;
                end
                FN_MOVZ: begin ctl.res = RES_PASS; ctl.wr = WR_IF_ZERO;    end
                FN_MOVN: begin ctl.res = RES_PASS; ctl.wr = WR_IF_NONZERO; end
                FN_MFHI: begin ctl.res = RES_HI;   ctl.wr = WR_ALWAYS;     end
                FN_MFLO: begin ctl.res = RES_LO;   ctl.wr = WR_ALWAYS;     end
                FN_MTHI: ctl.hi_we = 1'b1;
                FN_MTLO: ctl.lo_we = 1'b1;
                default: ;
            endcase
        end else begin
            ctl.dst_rt = 1'b1;
            unique case (op_code)
                OPC_ADDI, OPC_ADDIU: begin ctl.alu = ALU_ADD;  ctl.opb = OPB_SEXT; ctl.wr = WR_ALWAYS; end
                OPC_SLTI:            begin ctl.alu = ALU_SLT;  ctl.opb = OPB_SEXT; ctl.wr = WR_ALWAYS; end
                OPC_SLTIU:           begin ctl.alu = ALU_SLTU; ctl.opb = OPB_SEXT; ctl.wr = WR_ALWAYS; end
                OPC_ANDI:            begin ctl.alu = ALU_AND;  ctl.opb = OPB_ZEXT; ctl.wr = WR_ALWAYS; end
                OPC_ORI:             begin ctl.alu = ALU_OR;   ctl.opb = OPB_ZEXT; ctl.wr = WR_ALWAYS; end
                OPC_XORI:            begin ctl.alu = ALU_XOR;  ctl.opb = OPB_ZEXT; ctl.wr = WR_ALWAYS; end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exu_alu.sv
// Arithmetic, compare and bitwise unit. Addition wraps; no overflow trap.
// Assumes operand b already carries any immediate extension.
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y
);

    logic lt_s;
    logic lt_u;

    // Signed and unsigned less-than flags.
    always_comb begin
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
    end

    // Selects the operation result.
    always_comb begin
        unique case (fn)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_NOR:  y = ~(a | b);
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/exu_shifter.sv
// Barrel shifter for logical left, logical right and arithmetic right.
// Assumes the amount is already reduced to log2(XLEN) bits.
module exu_shifter
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val,
    input  logic [SHW-1:0]  amt,
    input  sh_kind_e        kind,
    output logic [XLEN-1:0] y
);

    // Applies the requested shift direction and fill.
    always_comb begin
        unique case (kind)
            SH_LL:   y = val << amt;
            SH_RL:   y = val >> amt;
            SH_RA:   y = $unsigned($signed(val) >>> amt);
            default: y = val;
        endcase
    end

endmodule

// File: rtl/exu_hilo.sv
// HI and LO special registers, loaded from one shared write value.
// Assumes the load enables are already qualified by issue.
module exu_hilo #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_we,
    input  logic            lo_we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] hi_q,
    output logic [XLEN-1:0] lo_q
);

    // Holds HI; cleared by reset, loaded by a move-to-HI.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_we) hi_q <= wdata;
    end

    // Holds LO; cleared by reset, loaded by a move-to-LO.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_we) lo_q <= wdata;
    end

    a_r7_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> (hi_q == $past(wdata)));
    a_r7_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> (lo_q == $past(wdata)));

endmodule

// File: rtl/int_exec_unit.sv
// Integer execute unit top: decodes the instruction fields, runs the ALU or
// shifter, reads or loads HI/LO, and applies the write-back policy.
// Assumes operands arrive already read from the register file.
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RIDX = 5,
    parameter int IMMW = 16,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [5:0]      op_code,
    input  logic [5:0]      fn_code,
    input  logic [SHW-1:0]  sh_amt,
    input  logic [RIDX-1:0] rt_sel,
    input  logic [RIDX-1:0] rd_sel,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [IMMW-1:0] imm16,
    output logic [XLEN-1:0] res,
    output logic [RIDX-1:0] wr_idx,
    output logic            wr_en
);

    ctl_t            ctl;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] sh_y;
    logic [SHW-1:0]  sh_n;
    logic [XLEN-1:0] hi_q;
    logic [XLEN-1:0] lo_q;
    logic            cond_ok;

    exu_decode u_dec (
        .op_code (op_code),
        .fn_code (fn_code),
        .ctl     (ctl)
    );

    // Chooses the second ALU operand: register or extended immediate.
    always_comb begin
        unique case (ctl.opb)
            OPB_SEXT: opb = {{(XLEN-IMMW){imm16[IMMW-1]}}, imm16};
            OPB_ZEXT: opb = {{(XLEN-IMMW){1'b0}}, imm16};
            default:  opb = rt_val;
        endcase
    end

    exu_alu #(.XLEN(XLEN)) u_alu (
        .a  (rs_val),
        .b  (opb),
        .fn (ctl.alu),
        .y  (alu_y)
    );

    // Picks the shift amount from the field or from the low bits of rs.
    always_comb sh_n = ctl.sh_var ? rs_val[SHW-1:0] : sh_amt;

    exu_shifter #(.XLEN(XLEN)) u_shf (
        .val  (rt_val),
        .amt  (sh_n),
        .kind (ctl.sh),
        .y    (sh_y)
    );

    exu_hilo #(.XLEN(XLEN)) u_hilo (
        .clk   (clk),
        .rst_n (rst_n),
        .hi_we (issue & ctl.hi_we),
        .lo_we (issue & ctl.lo_we),
        .wdata (rs_val),
        .hi_q  (hi_q),
        .lo_q  (lo_q)
    );

    // Selects the write-back value.
    always_comb begin
        unique case (ctl.res)
            RES_SHIFT: res = sh_y;
            RES_HI:    res = hi_q;
            RES_LO:    res = lo_q;
            RES_PASS:  res = rs_val;
            default:   res = alu_y;
        endcase
    end

    // Evaluates the write policy, including the conditional moves.
    always_comb begin
        unique case (ctl.wr)
            WR_ALWAYS:     cond_ok = 1'b1;
            WR_IF_ZERO:    cond_ok = (rt_val == '0);
            WR_IF_NONZERO: cond_ok = (rt_val != '0);
            default:       cond_ok = 1'b0;
        endcase
    end

    // Forms the destination index and the final write enable.
    always_comb begin
        wr_idx = ctl.dst_rt ? rt_sel : rd_sel;
        wr_en  = issue && cond_ok && (wr_idx != '0);
    end

    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != '0));
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |-> !wr_en);
    a_r8_movz_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_SPECIAL && fn_code == FN_MOVZ && rt_val != '0) |-> !wr_en);
    a_r8_movn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_SPECIAL && fn_code == FN_MOVN && rt_val == '0) |-> !wr_en);
    a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 6'd15 || (op_code == OPC_SPECIAL && (fn_code == 6'd1 || fn_code == 6'd5))) |-> !wr_en);
    a_r7_mt_no_gpr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_SPECIAL && (fn_code == FN_MTHI || fn_code == FN_MTLO)) |-> !wr_en);

endmodule

// File: tb/tb_int_exec_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [5:0]  op_code = '0;
    logic [5:0]  fn_code = '0;
    logic [4:0]  sh_amt = '0;
    logic [4:0]  rt_sel = '0;
    logic [4:0]  rd_sel = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] res;
    logic [4:0]  wr_idx;
    logic        wr_en;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    int_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
        .fn_code(fn_code), .sh_amt(sh_amt), .rt_sel(rt_sel), .rd_sel(rd_sel),
        .rs_val(rs_val), .rt_val(rt_val), .imm16(imm16),
        .res(res), .wr_idx(wr_idx), .wr_en(wr_en)
    );

    // Drives one instruction after a falling edge and settles.
    task automatic drive(input logic iss, input logic [5:0] op, input logic [5:0] fn,
                         input logic [4:0] sh, input logic [4:0] rt, input logic [4:0] rd,
                         input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
        @(negedge clk);
        issue = iss; op_code = op; fn_code = fn; sh_amt = sh;
        rt_sel = rt; rd_sel = rd; rs_val = a; rt_val = b; imm16 = im;
        #1;
    endtask

    // Compares outputs; result and index only matter when a write is expected.
    task automatic check(input string tag, input logic exp_we,
                         input logic [31:0] exp_res, input logic [4:0] exp_idx);
        n_checks++;
        if (wr_en !== exp_we || (exp_we && (res !== exp_res || wr_idx !== exp_idx))) begin
            n_fail++;
            $display("FAIL %s: we=%0b res=%h idx=%0d expected we=%0b res=%h idx=%0d",
                     tag, wr_en, res, wr_idx, exp_we, exp_res, exp_idx);
        end
    endtask

    task automatic t_reset;
        drive(1, 6'd0, 6'd16, 0, 0, 26, 0, 0, 0);
        check("R11 HI after reset", 1, 32'h0, 26);
        drive(1, 6'd0, 6'd18, 0, 0, 26, 0, 0, 0);
        check("R11 LO after reset", 1, 32'h0, 26);
    endtask

    task automatic t_addsub;
        drive(1, 6'd0, 6'd32, 0, 25, 26, 24, 12, 0);      check("R1 ADD", 1, 36, 26);
        drive(1, 6'd0, 6'd33, 0, 25, 26, 32'h7FFFFFFF, 1, 0); check("R1 ADDU wrap", 1, 32'h80000000, 26);
        drive(1, 6'd0, 6'd32, 0, 25, 26, 32'h7FFFFFFF, 1, 0); check("R1 ADD no trap", 1, 32'h80000000, 26);
        drive(1, 6'd0, 6'd34, 0, 25, 26, 24, 12, 0);      check("R1 SUB", 1, 12, 26);
        drive(1, 6'd0, 6'd35, 0, 25, 26, 0, 1, 0);        check("R1 SUBU wrap", 1, 32'hFFFFFFFF, 26);
    endtask

    task automatic t_imm_add;
        drive(1, 6'd8, 0, 0, 26, 9, 24, 0, 16'd12);       check("R2 ADDI to rt", 1, 36, 26);
        drive(1, 6'd9, 0, 0, 7, 9, 24, 0, 16'hFFFF);      check("R2 ADDIU sext", 1, 23, 7);
    endtask

    task automatic t_slt;
        drive(1, 6'd0, 6'd42, 0, 25, 26, 12, 24, 0);      check("R3 SLT", 1, 1, 26);
        drive(1, 6'd0, 6'd42, 0, 25, 26, 32'hFFFFFFFF, 1, 0); check("R3 SLT signed", 1, 1, 26);
        drive(1, 6'd0, 6'd43, 0, 25, 26, 32'hFFFFFFFF, 1, 0); check("R3 SLTU", 1, 0, 26);
        drive(1, 6'd10, 0, 0, 26, 0, 5, 0, 16'hFFFF);     check("R3 SLTI", 1, 0, 26);
        drive(1, 6'd11, 0, 0, 26, 0, 5, 0, 16'hFFFF);     check("R3 SLTIU sext unsigned", 1, 1, 26);
    endtask

    task automatic t_logic;
        drive(1, 6'd0, 6'd36, 0, 25, 26, 32'hF0, 32'hE1, 0); check("R4 AND", 1, 32'hE0, 26);
        drive(1, 6'd0, 6'd37, 0, 25, 26, 32'hF0, 32'hE1, 0); check("R4 OR", 1, 32'hF1, 26);
        drive(1, 6'd0, 6'd38, 0, 25, 26, 32'hF0, 32'hE1, 0); check("R4 XOR", 1, 32'h11, 26);
        drive(1, 6'd0, 6'd39, 0, 25, 26, 32'hF0, 32'hE1, 0); check("R4 NOR", 1, 32'hFFFFFF0E, 26);
        drive(1, 6'd12, 0, 0, 26, 0, 32'hFFFFFFFF, 0, 16'h8000); check("R4 ANDI zext", 1, 32'h00008000, 26);
        drive(1, 6'd13, 0, 0, 26, 0, 32'h00000F00, 0, 16'h8001); check("R4 ORI zext", 1, 32'h00008F01, 26);
        drive(1, 6'd14, 0, 0, 26, 0, 32'hFFFF0000, 0, 16'h8001); check("R4 XORI zext", 1, 32'hFFFF8001, 26);
    endtask

    task automatic t_shift_imm;
        drive(1, 6'd0, 6'd0, 3, 24, 26, 0, 32'hF0, 0);        check("R5 SLL", 1, 32'h780, 26);
        drive(1, 6'd0, 6'd2, 3, 24, 26, 0, 32'hF0, 0);        check("R5 SRL", 1, 32'h1E, 26);
        drive(1, 6'd0, 6'd2, 3, 24, 26, 0, 32'h800000F0, 0);  check("R5 SRL zero fill", 1, 32'h1000001E, 26);
        drive(1, 6'd0, 6'd3, 3, 24, 26, 0, 32'h800000F0, 0);  check("R5 SRA", 1, 32'hF000001E, 26);
    endtask

    task automatic t_shift_var;
        drive(1, 6'd0, 6'd4, 0, 24, 26, 32'h23, 32'hF0, 0);      check("R6 SLLV low bits", 1, 32'h780, 26);
        drive(1, 6'd0, 6'd6, 0, 24, 26, 3, 32'hF0, 0);           check("R6 SRLV", 1, 32'h1E, 26);
        drive(1, 6'd0, 6'd7, 0, 24, 26, 32'hFFFFFFE3, 32'h800000F0, 0); check("R6 SRAV low bits", 1, 32'hF000001E, 26);
    endtask

    task automatic t_hilo;
        drive(1, 6'd0, 6'd17, 0, 0, 0, 21, 0, 0);  check("R7 MTHI no write", 0, 0, 0);
        drive(1, 6'd0, 6'd19, 0, 0, 0, 22, 0, 0);  check("R7 MTLO no write", 0, 0, 0);
        drive(1, 6'd0, 6'd16, 0, 0, 26, 0, 0, 0);  check("R7 MFHI", 1, 21, 26);
        drive(1, 6'd0, 6'd18, 0, 0, 26, 0, 0, 0);  check("R7 MFLO", 1, 22, 26);
    endtask

    task automatic t_movc;
        drive(1, 6'd0, 6'd10, 0, 1, 25, 55, 0, 0); check("R8 MOVZ true", 1, 55, 25);
        drive(1, 6'd0, 6'd10, 0, 1, 25, 55, 1, 0); check("R8 MOVZ false", 0, 0, 0);
        drive(1, 6'd0, 6'd11, 0, 1, 25, 55, 7, 0); check("R8 MOVN true", 1, 55, 25);
        drive(1, 6'd0, 6'd11, 0, 1, 25, 55, 0, 0); check("R8 MOVN false", 0, 0, 0);
    endtask

    task automatic t_zero_dest;
        drive(1, 6'd0, 6'd32, 0, 25, 0, 24, 12, 0); check("R9 ADD to r0", 0, 0, 0);
        drive(1, 6'd8, 0, 0, 0, 26, 24, 0, 16'd1);  check("R9 ADDI to r0", 0, 0, 0);
    endtask

    task automatic t_unknown;
        drive(1, 6'd0, 6'd1, 0, 25, 26, 21, 1, 0);  check("R10 funct 1", 0, 0, 0);
        drive(1, 6'd0, 6'd5, 0, 25, 26, 21, 1, 0);  check("R10 funct 5", 0, 0, 0);
        drive(1, 6'd15, 0, 0, 26, 26, 99, 1, 0);    check("R10 opcode 15", 0, 0, 0);
        drive(1, 6'd0, 6'd16, 0, 0, 26, 0, 0, 0);   check("R10 HI kept", 1, 21, 26);
    endtask

    task automatic t_idle;
        drive(0, 6'd0, 6'd32, 0, 25, 26, 1, 2, 0);  check("R12 idle no write", 0, 0, 0);
        drive(0, 6'd0, 6'd17, 0, 0, 0, 99, 0, 0);   check("R12 idle MTHI", 0, 0, 0);
        drive(1, 6'd0, 6'd16, 0, 0, 26, 0, 0, 0);   check("R12 HI kept", 1, 21, 26);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_addsub;
        t_imm_add;
        t_slt;
        t_logic;
        t_shift_imm;
        t_shift_var;
        t_hilo;
        t_movc;
        t_zero_dest;
        t_unknown;
        t_idle;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule